// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine for a 16-bit-per-pixel framebuffer. Software controls it only through register writes. Each write enters a command queue. While the engine is drawing, writes wait in that queue and are applied in order once it is idle. The engine has two operations. A solid fill writes one foreground colour to every pixel of a rectangle. A copy moves a rectangle of pixels from a source area to a destination area. It reads each pixel and then writes it, one pixel at a time.

Each area has a base offset and a pitch, both counted in pixels. A pixel lives at `base + y*pitch + x`. Every destination pixel is tested against an inclusive clip window. During a copy, every source pixel is also tested against a source limit. Direction bits set whether x and y are walked upward or downward, and whether the walk runs along rows or along columns. Writing the size register launches the operation. It uses the values most recently written to the other registers. A single status word reports the free queue slots and whether the engine is active.

Top module: `rect_blitter`

## Requirements
- R1: After reset the status word reads 16 free slots with the active bit clear, and no memory request is made.
- R2: Register indices are: 0 dst base, 1 dst pitch, 2 src base, 3 src pitch, 4 clip top-left, 5 clip bottom-right, 6 src limit, 7 mode, 8 colour, 9 direction, 10 src origin, 11 dst origin, 12 size (launches); 13-15 are ignored. Status bits 6:0 give the free queue slots and bit 31 the active flag. While drawing, each queued write lowers the free count by one.
- R3: A register write that arrives when the queue is full is dropped.
- R4: Mode bits 7:0 = 0xF0 with bits 11:8 = 13 selects fill. Fill writes colour bits 15:0 once per pixel. Origins pack y in bits 31:16 and x in bits 15:0. Size packs width in bits 31:16 and height in bits 15:0.
- R5: Mode 0xCC with bits 11:8 = 15 and bits 14:12 = 2 selects copy. For each pixel the source read is accepted and its data returned before the matching destination write is issued.
- R6: A destination pixel is drawn only if tl.x <= x <= br.x and tl.y <= y <= br.y, each register packed as (y<<16)|x. A copy pixel outside the window is neither read nor written. After reset the window is 0 to 0x1FFF on both axes.
- R7: A copy pixel whose source x or y exceeds the source limit ((y<<16)|x, reset 0x1FFF each) is neither read nor written.
- R8: Direction bit 0 (dst x) and bit 1 (dst y) set the walk: 1 steps upward from the origin, and 0 steps downward from origin+extent-1. Bits 2 and 3 do the same for the source. After reset the direction register is 0x1F.
- R9: Direction bit 4 = 1 finishes each row before the next y; 0 finishes each column before the next x.
- R10: A zero width or zero height makes no memory access, raises active for two cycles and then returns to idle.
- R11: A mode matching neither fill nor copy makes no memory access.
- R12: Active is high from the launch until the last pixel access has been accepted. No memory request is made while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Free slots in bits 6:0, active in bit 31 |
| mem_req | output | 1 | Pixel memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Pixel address |
| mem_wdata | output | 16 | Write pixel |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read pixel |

## Verification
Fills are run with the default walk order, with both destination axes reversed, and with column-first order. Comparing the sequences of write addresses shows whether the direction bits and the major-axis bit are honoured. A copy checks that each read comes before its write and that the data moves to the right place. Clip-window and source-limit cases check which pixels are skipped. Zero-sized and unknown-mode launches must make no access at all. A long fill keeps the engine busy while the queue is flooded. This shows the free count falling, the writes that arrive when full being dropped, and the last accepted colour being the one used.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_FILL, OP_COPY} op_e;

  localparam logic [7:0] ROP_SRC     = 8'hCC;
  localparam logic [7:0] ROP_PAT     = 8'hF0;
  localparam logic [3:0] BRUSH_SOLID = 4'd13;
  localparam logic [3:0] BRUSH_OFF   = 4'd15;
  localparam logic [2:0] SRC_RECT    = 3'd2;

  localparam logic [3:0] IX_DBASE = 4'd0;
  localparam logic [3:0] IX_DPIT  = 4'd1;
  localparam logic [3:0] IX_SBASE = 4'd2;
  localparam logic [3:0] IX_SPIT  = 4'd3;
  localparam logic [3:0] IX_CLTL  = 4'd4;
  localparam logic [3:0] IX_CLBR  = 4'd5;
  localparam logic [3:0] IX_SLIM  = 4'd6;
  localparam logic [3:0] IX_MODE  = 4'd7;
  localparam logic [3:0] IX_FG    = 4'd8;
  localparam logic [3:0] IX_DIR   = 4'd9;
  localparam logic [3:0] IX_SYX   = 4'd10;
  localparam logic [3:0] IX_DYX   = 4'd11;
  localparam logic [3:0] IX_SIZE  = 4'd12;

  typedef struct packed {
    logic [31:0] dbase, dpitch, sbase, spitch;
    logic [31:0] clip_tl, clip_br, slim;
    logic [31:0] mode, fg, dir;
    logic [31:0] syx, dyx, size;
  } cfg_t;

  function automatic op_e decode_op(logic [31:0] mode);
    if (mode[7:0] == ROP_PAT && mode[11:8] == BRUSH_SOLID) return OP_FILL;
    if (mode[7:0] == ROP_SRC && mode[11:8] == BRUSH_OFF && mode[14:12] == SRC_RECT)
      return OP_COPY;
    return OP_NONE;
  endfunction

  function automatic logic [15:0] walk_coord(logic [15:0] org, logic [15:0] ext,
                                             logic [15:0] idx, logic up);
    return up ? org + idx : org + ext - 16'd1 - idx;
  endfunction

  function automatic logic in_window(logic [15:0] x, logic [15:0] y,
                                     logic [31:0] tl, logic [31:0] br);
    return (x >= tl[15:0]) && (x <= br[15:0]) && (y >= tl[31:16]) && (y <= br[31:16]);
  endfunction

  function automatic logic [31:0] pix_addr(logic [31:0] base, logic [31:0] pitch,
                                           logic [15:0] x, logic [15:0] y);
    return base + {16'd0, y} * pitch + {16'd0, x};
  endfunction
endpackage

// File: rtl/blit_cmd_fifo.sv
module blit_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 36,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic [CNT_W-1:0] free
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             full, do_push, do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rp];
  assign free    = CNT_W'(DEPTH) - cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) begin
        store[wp] <= din;
        wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (free == '0));
endmodule

// File: rtl/blit_regfile.sv
module blit_regfile
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        apply,
  input  logic [3:0]  idx,
  input  logic [31:0] data,
  output cfg_t        cfg,
  output logic        launch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg         <= '0;
      cfg.clip_br <= 32'h1FFF_1FFF;
      cfg.slim    <= 32'h1FFF_1FFF;
      cfg.dir     <= 32'h0000_001F;
      launch      <= 1'b0;
    end else begin
      launch <= apply && (idx == IX_SIZE);
      if (apply) begin
        case (idx)
          IX_DBASE: cfg.dbase   <= data;
          IX_DPIT:  cfg.dpitch  <= data;
          IX_SBASE: cfg.sbase   <= data;
          IX_SPIT:  cfg.spitch  <= data;
          IX_CLTL:  cfg.clip_tl <= data;
          IX_CLBR:  cfg.clip_br <= data;
          IX_SLIM:  cfg.slim    <= data;
          IX_MODE:  cfg.mode    <= data;
          IX_FG:    cfg.fg      <= data;
          IX_DIR:   cfg.dir     <= data;
          IX_SYX:   cfg.syx     <= data;
          IX_DYX:   cfg.dyx     <= data;
          IX_SIZE:  cfg.size    <= data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cfg_t              cfg,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_PIX, S_RDW, S_WR, S_FIN} st_e;
  st_e         st;
  op_e         op_q;
  logic [15:0] cx, cy, pix_q;
  logic        have_data;

  logic [15:0] w, h, dst_x, dst_y, src_x, src_y;
  logic        zero_sz, dst_ok, src_ok, vis, last, step, row_major;
  logic        wr_beat, rd_beat;
  logic [31:0] dst_a, src_a;

  assign w         = cfg.size[31:16];
  assign h         = cfg.size[15:0];
  assign zero_sz   = (w == 16'd0) || (h == 16'd0);
  assign row_major = cfg.dir[4];
  assign dst_x = walk_coord(cfg.dyx[15:0],  w, cx, cfg.dir[0]);
  assign dst_y = walk_coord(cfg.dyx[31:16], h, cy, cfg.dir[1]);
  assign src_x = walk_coord(cfg.syx[15:0],  w, cx, cfg.dir[2]);
  assign src_y = walk_coord(cfg.syx[31:16], h, cy, cfg.dir[3]);
  assign dst_a = pix_addr(cfg.dbase, cfg.dpitch, dst_x, dst_y);
  assign src_a = pix_addr(cfg.sbase, cfg.spitch, src_x, src_y);
  assign dst_ok = in_window(dst_x, dst_y, cfg.clip_tl, cfg.clip_br);
  assign src_ok = (op_q != OP_COPY) ||
                  ((src_x <= cfg.slim[15:0]) && (src_y <= cfg.slim[31:16]));
  assign vis   = dst_ok && src_ok;
  assign last  = (cx == w - 16'd1) && (cy == h - 16'd1);
  assign busy  = (st != S_IDLE);
  assign wr_beat = mem_req && mem_we && mem_ready;
  assign rd_beat = mem_req && !mem_we && mem_ready;

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; step = 1'b0;
    case (st)
      S_PIX: begin
        if (!vis) step = 1'b1;
        else if (op_q == OP_FILL) begin
          mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_a[ADDR_W-1:0];
          mem_wdata = cfg.fg[15:0]; step = mem_ready;
        end else begin
          mem_req = 1'b1; mem_addr = src_a[ADDR_W-1:0];
        end
      end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_a[ADDR_W-1:0];
        mem_wdata = pix_q; step = mem_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_NONE; cx <= '0; cy <= '0; pix_q <= '0;
      have_data <= 1'b0;
    end else begin
      if (mem_rvalid) have_data <= 1'b1;
      else if (wr_beat) have_data <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= decode_op(cfg.mode);
          cx <= '0; cy <= '0;
          st <= (zero_sz || decode_op(cfg.mode) == OP_NONE) ? S_FIN : S_PIX;
        end
        S_PIX:  if (vis && op_q == OP_COPY && mem_ready) st <= S_RDW;
        S_RDW:  if (mem_rvalid) begin pix_q <= mem_rdata; st <= S_WR; end
        S_FIN:  st <= S_IDLE;
        default: ;
      endcase
      if (step) begin
        if (last) st <= S_IDLE;
        else begin
          st <= S_PIX;
          if (row_major) begin
            if (cx == w - 16'd1) begin cx <= '0; cy <= cy + 16'd1; end
            else cx <= cx + 16'd1;
          end else begin
            if (cy == h - 16'd1) begin cy <= '0; cx <= cx + 16'd1; end
            else cy <= cy + 16'd1;
          end
        end
      end
    end
  end

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R5
  copy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && op_q == OP_COPY) |-> have_data);
  // R5
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |=> !mem_req);
  // R6
  clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |-> in_window(dst_x, dst_y, cfg.clip_tl, cfg.clip_br));
  // R10
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zero_sz) |=> (busy && !mem_req));
  // R10
  zero_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zero_sz) |=> ##1 !busy);
endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
  import blit_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W = 4 + 32;

  logic [ENT_W-1:0] head;
  logic             q_empty, pop, launch, busy, active;
  logic [CNT_W-1:0] free;
  cfg_t             cfg;

  assign pop    = !q_empty && !busy && !launch;
  assign active = busy || launch;
  assign status = {active, 24'd0, 7'(free)};

  blit_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk, .rst_n, .push(reg_wr), .din({reg_idx, reg_wdata}), .pop,
    .dout(head), .empty(q_empty), .free
  );

  blit_regfile u_regs (
    .clk, .rst_n, .apply(pop), .idx(head[35:32]), .data(head[31:0]),
    .cfg, .launch
  );

  blit_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk, .rst_n, .start(launch), .cfg, .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rvalid, .mem_rdata
  );

  // R12
  launch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> status[31]);
endmodule

// File: tb/rect_blitter_test.sv
module rect_blitter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mem_ready = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] mem [4096];
  logic        ev_we [1024];
  int          ev_addr [1024];
  logic [15:0] ev_data [1024];
  int          ev_n = 0;
  logic [1:0]  rdy_cnt = '0;

  rect_blitter #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) uut (
    .clk, .rst_n, .reg_wr, .reg_idx, .reg_wdata, .status,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rvalid, .mem_rdata
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 3 + 1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy_cnt <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
    mem_ready <= (rdy_cnt != 2'd1);
    mem_rvalid <= 1'b0;
    if (mem_req && mem_ready) begin
      if (ev_n < 1024) begin
        ev_we[ev_n] <= mem_we; ev_addr[ev_n] <= int'(mem_addr);
        ev_data[ev_n] <= mem_we ? mem_wdata : mem[mem_addr];
      end
      ev_n <= ev_n + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin mem_rvalid <= 1'b1; mem_rdata <= mem[mem_addr]; end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
    summary();
    $finish;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (!(status[6:0] == 7'(DEPTH) && !status[31]) && n < 20000) begin
      @(negedge clk); n++;
    end
    check(n < 20000, "R12 engine returns idle", n, 0);
  endtask

  task automatic expect_ev(input int k, input logic we, input int a, input int d, input string tag);
    check(ev_we[k] == we && ev_addr[k] == a && int'(ev_data[k]) == d, tag,
          ev_addr[k] * 65536 + int'(ev_data[k]), a * 65536 + d);
  endtask

  task automatic setup(input int dbase, input int dpitch, input int mode, input int dir);
    wr(4'd0, 32'(dbase)); wr(4'd1, 32'(dpitch)); wr(4'd7, 32'(mode)); wr(4'd9, 32'(dir));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(status == 32'(DEPTH), "R1 status after reset", int'(status), DEPTH);
    check(!mem_req, "R1 no request after reset", int'(mem_req), 0);
  endtask

  task automatic t_fill();
    int b = ev_n;
    setup(100, 10, 32'h0DF0, 32'h1F);
    wr(4'd8, 32'hABCD); wr(4'd11, {16'd1, 16'd2}); wr(4'd12, {16'd3, 16'd2});
    wait_idle();
    check(ev_n - b == 6, "R4 fill pixel count", ev_n - b, 6);
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 3; x++)
        expect_ev(b + y*3 + x, 1'b1, 100 + (1+y)*10 + 2 + x, 16'hABCD, "R4 fill write");
  endtask

  task automatic t_copy();
    int b = ev_n;
    int sa [4] = '{1, 2, 9, 10};
    int da [4] = '{245, 246, 253, 254};
    setup(200, 8, 32'h2FCC, 32'h1F);
    wr(4'd2, 0); wr(4'd3, 8); wr(4'd10, {16'd0, 16'd1}); wr(4'd11, {16'd5, 16'd5});
    wr(4'd12, {16'd2, 16'd2});
    wait_idle();
    check(ev_n - b == 8, "R5 copy access count", ev_n - b, 8);
    for (int k = 0; k < 4; k++) begin
      expect_ev(b + 2*k, 1'b0, sa[k], sa[k]*3 + 1, "R5 copy read first");
      expect_ev(b + 2*k + 1, 1'b1, da[k], sa[k]*3 + 1, "R5 copy write after read");
    end
  endtask

  task automatic t_clip();
    int b = ev_n;
    setup(300, 10, 32'h0DF0, 32'h1F);
    wr(4'd4, {16'd1, 16'd1}); wr(4'd5, {16'd2, 16'd2});
    wr(4'd8, 32'h5A5A); wr(4'd11, 0); wr(4'd12, {16'd4, 16'd4});
    wait_idle();
    check(ev_n - b == 4, "R6 clipped pixel count", ev_n - b, 4);
    expect_ev(b, 1'b1, 311, 16'h5A5A, "R6 first visible");
    expect_ev(b + 3, 1'b1, 322, 16'h5A5A, "R6 last visible");
    check(mem[300] == 16'(301*3 - 2), "R6 pixel outside untouched", mem[300], 300*3 + 1);
    wr(4'd4, 0); wr(4'd5, 32'h1FFF_1FFF);
  endtask

  task automatic t_srclim();
    int b = ev_n;
    setup(400, 8, 32'h2FCC, 32'h1F);
    wr(4'd6, {16'h1FFF, 16'd1}); wr(4'd10, 0); wr(4'd11, 0);
    wr(4'd12, {16'd3, 16'd1});
    wait_idle();
    check(ev_n - b == 4, "R7 source-limited accesses", ev_n - b, 4);
    check(mem[400] == 16'd1 && mem[401] == 16'd4, "R7 copied pixels",
          {mem[400], mem[401]}, 32'h0001_0004);
    check(mem[402] == 16'(402*3 + 1), "R7 skipped pixel", mem[402], 402*3 + 1);
    wr(4'd6, 32'h1FFF_1FFF);
  endtask

  task automatic t_reverse();
    int b = ev_n;
    int ex [4] = '{511, 510, 501, 500};
    setup(500, 10, 32'h0DF0, 32'h1C);
    wr(4'd8, 32'h1111); wr(4'd11, 0); wr(4'd12, {16'd2, 16'd2});
    wait_idle();
    for (int k = 0; k < 4; k++) expect_ev(b + k, 1'b1, ex[k], 16'h1111, "R8 reversed order");
  endtask

  task automatic t_colmajor();
    int b = ev_n;
    int ex [4] = '{500, 510, 501, 511};
    setup(500, 10, 32'h0DF0, 32'h0F);
    wr(4'd8, 32'h2222); wr(4'd11, 0); wr(4'd12, {16'd2, 16'd2});
    wait_idle();
    for (int k = 0; k < 4; k++) expect_ev(b + k, 1'b1, ex[k], 16'h2222, "R9 column order");
  endtask

  task automatic t_zero();
    int b = ev_n;
    setup(600, 10, 32'h0DF0, 32'h1F);
    wr(4'd12, {16'd0, 16'd5});
    wait_idle();
    wr(4'd12, {16'd4, 16'd0});
    wait_idle();
    check(ev_n == b, "R10 zero size makes no access", ev_n - b, 0);
  endtask

  task automatic t_badmode();
    int b = ev_n;
    setup(600, 10, 32'h0D66, 32'h1F);
    wr(4'd12, {16'd2, 16'd2});
    wait_idle();
    check(ev_n == b, "R11 unknown mode no access", ev_n - b, 0);
  endtask

  task automatic t_queue();
    int b = ev_n;
    setup(1000, 8, 32'h0DF0, 32'h1F);
    wr(4'd8, 32'h3333); wr(4'd11, 0); wr(4'd12, {16'd8, 16'd8});
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) wr(4'd8, 32'h4000 + k);
    check(status[6:0] == 7'(DEPTH - 5), "R2 free count drops while busy",
          status[6:0], DEPTH - 5);
    check(status[31], "R12 active while drawing", status[31], 1);
    for (int k = 5; k < 20; k++) wr(4'd8, 32'h4000 + k);
    check(status[6:0] == 7'd0, "R3 queue full", status[6:0], 0);
    wait_idle();
    check(ev_n - b == 64, "R12 all pixels done before idle", ev_n - b, 64);
    check(mem[1063] == 16'h3333, "R4 last pixel of long fill", mem[1063], 16'h3333);
    b = ev_n;
    wr(4'd0, 2000); wr(4'd12, {16'd1, 16'd1});
    wait_idle();
    check(ev_n - b == 1, "R3 single pixel after overflow", ev_n - b, 1);
    check(mem[2000] == 16'h400F, "R3 overflow writes dropped", mem[2000], 16'h400F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_copy();
    t_clip();
    t_srclim();
    t_reverse();
    t_colmajor();
    t_zero();
    t_badmode();
    t_queue();
    summary();
    $finish;
  end
endmodule